// File: doc/BRIEF.md
# Grid-Encoded Fully Associative Translation Buffer

This block translates 32-bit virtual addresses with 4 KB pages through a 64-entry fully associative buffer. Each entry has two parts. A match key (20-bit virtual page number, 6-bit address-space identifier and a global flag) sits in a compare array. The translation payload (20-bit physical frame number plus non-cacheable, dirty and valid flags) sits in a separate indexed RAM. A lookup compares the page number and identifier against all 64 keys in parallel.

The compare cells are arranged as an 8x8 grid, and no flat 64-input priority encoder is used. Every matching cell raises the OR-ed line of its row and the OR-ed line of its column. The row coordinate and the column coordinate are each recovered from their eight lines, and the two are joined into the 6-bit entry index, which then reads the payload RAM. More than one active row line or column line signals an ambiguous match. Software-side control fills and inspects entries through an indexed write port and an indexed read port.

Top module: `tlb_grid_top`

## Requirements
- R1: While reset is low and on the first cycle after reset, lk_hit, lk_multi, lk_index, lk_pa, the lookup flags and all read-port outputs are 0. Every entry is marked unused and matches nothing until it is written.
- R2: A written entry matches a lookup when its page number equals lk_va[31:12] and either its global flag is set or its identifier equals lk_asid. The result appears on the outputs one clock edge after lk_va and lk_asid are presented.
- R3: For an entry whose global flag is 1, the identifier comparison is ignored, so a lookup with any lk_asid value hits it.
- R4: For an entry whose global flag is 0, a lookup with the right page number and a different identifier is a miss.
- R5: Entry i sits at grid row i[5:3] and column i[2:0]. On a single match, lk_index reports {row, column}, which equals i.
- R6: On a hit, lk_pa equals {stored frame number, lk_va[11:0]}, and lk_nocache, lk_dirty and lk_pvalid carry the stored payload flags of the hit entry.
- R7: When no entry matches, lk_hit = 0, lk_multi = 0, and lk_index, lk_pa and the three flags are 0.
- R8: When two or more entries match, whether they differ in row, in column or in both, lk_multi = 1, lk_hit = 0, and lk_index, lk_pa and the flags are 0.
- R9: With wr_en = 1, one clock edge replaces the key and the payload of entry wr_idx together. A lookup presented in the same cycle as the write sees the old contents. A lookup in the next cycle sees the new contents.
- R10: The read port returns the key (rd_vpn, rd_asid, rd_glob) and payload (rd_pfn, rd_nocache, rd_dirty, rd_pvalid) of entry rd_idx one clock edge after rd_idx is presented. A write in the previous cycle is already visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Address-space identifier of the lookup |
| wr_en | input | 1 | Indexed write strobe |
| wr_idx | input | 6 | Entry written |
| wr_vpn | input | 20 | Page number key to store |
| wr_asid | input | 6 | Identifier key to store |
| wr_glob | input | 1 | Global flag to store |
| wr_pfn | input | 20 | Physical frame number to store |
| wr_nocache | input | 1 | Non-cacheable flag to store |
| wr_dirty | input | 1 | Dirty flag to store |
| wr_pvalid | input | 1 | Payload valid flag to store |
| rd_idx | input | 6 | Entry inspected by the read port |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_multi | output | 1 | More than one entry matched |
| lk_index | output | 6 | Index of the hit entry |
| lk_pa | output | 32 | Translated physical address |
| lk_nocache | output | 1 | Non-cacheable flag of the hit |
| lk_dirty | output | 1 | Dirty flag of the hit |
| lk_pvalid | output | 1 | Valid flag of the hit |
| rd_vpn | output | 20 | Page number of the inspected entry |
| rd_asid | output | 6 | Identifier of the inspected entry |
| rd_glob | output | 1 | Global flag of the inspected entry |
| rd_pfn | output | 20 | Frame number of the inspected entry |
| rd_nocache | output | 1 | Non-cacheable flag of the inspected entry |
| rd_dirty | output | 1 | Dirty flag of the inspected entry |
| rd_pvalid | output | 1 | Valid flag of the inspected entry |

## Verification
Lookups are run against each of the 64 entries with a different page offset each time. A wrong row or column bit in the rebuilt index therefore shows up as a wrong lk_index or a wrong frame. Global entries are probed with a foreign identifier and non-global entries with an off-by-one identifier, which separates the global override from plain identifier matching. Unmapped pages give a clean miss. Two deliberate duplicates are loaded: one spans different rows and columns, and one shares a row so that only the column lines reveal it. A write issued together with a lookup of its own key, followed by a lookup in the next cycle, separates old-content from new-content visibility.

// File: rtl/tlb_pkg.sv
// Shared widths and record layouts for the grid-encoded translation buffer.
// Assumes 32-bit virtual and physical addresses with 4 KB pages.
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = 20;
    localparam int ASID_W = 6;

    // Match key held in the compare array (27 bits).
    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glob;
    } tlb_key_t;

    // Translation payload held in the indexed RAM.
    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             nocache;
        logic             dirty;
        logic             pvalid;
    } tlb_pay_t;
endpackage

// File: rtl/tlb_key_cam.sv
// Compare array: stores one match key per entry plus a written marker and
// raises one match line per entry. Assumes ENTRIES is a power of two.
module tlb_key_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_key_t          wr_key,
    input  logic [IDX_W-1:0]  rd_idx,
    output tlb_key_t          rd_key,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [ENTRIES-1:0] match
);
    tlb_key_t           keys [ENTRIES];
    logic [ENTRIES-1:0] used;

    // Store a key on an indexed write and mark the entry as live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
            for (int e = 0; e < ENTRIES; e++) keys[e] <= '0;
        end else if (wr_en) begin
            keys[wr_idx] <= wr_key;
            used[wr_idx] <= 1'b1;
        end
    end

    // One compare cell per entry; the global flag masks the identifier.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
        assign match[e] = used[e] && (keys[e].vpn == lk_vpn) &&
                          (keys[e].glob || (keys[e].asid == lk_asid));
    end

    // Indexed inspection of a stored key.
    assign rd_key = keys[rd_idx];

    // An entry written last cycle is live now.
    AST_WRITE_MARKS_USED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> used[$past(wr_idx)]); // R9
endmodule

// File: rtl/tlb_grid_enc.sv
// Grid encoder: treats DIM*DIM match lines as a DIM x DIM grid, ORs them
// onto row and column lines, and rebuilds each coordinate by OR-ing the
// numbers of the active lines. Assumes match bit r*DIM+c is row r, col c.
module tlb_grid_enc #(
    parameter int DIM   = 8,
    parameter int CRD_W = $clog2(DIM)
) (
    input  logic [DIM*DIM-1:0] match,
    output logic [CRD_W-1:0]   row_crd,
    output logic [CRD_W-1:0]   col_crd,
    output logic               any,
    output logic               multi
);
    logic [DIM-1:0] row_line;
    logic [DIM-1:0] col_line;

    // Wired-OR of each row and each column of the grid.
    for (genvar r = 0; r < DIM; r++) begin : g_row
        assign row_line[r] = |match[r*DIM +: DIM];
    end
    for (genvar c = 0; c < DIM; c++) begin : g_col
        logic [DIM-1:0] bits;
        for (genvar r = 0; r < DIM; r++) begin : g_tap
            assign bits[r] = match[r*DIM + c];
        end
        assign col_line[c] = |bits;
    end

    function automatic logic [CRD_W-1:0] line_to_crd(input logic [DIM-1:0] l);
        logic [CRD_W-1:0] crd;
        crd = '0;
        for (int k = 0; k < DIM; k++) if (l[k]) crd = crd | CRD_W'(k);
        return crd;
    endfunction

    function automatic logic several(input logic [DIM-1:0] l);
        return (l & (l - 1'b1)) != '0;
    endfunction

    // Coordinate rebuild and ambiguity detection from the shared lines.
    always_comb begin
        row_crd = line_to_crd(row_line);
        col_crd = line_to_crd(col_line);
        any     = |row_line;
        multi   = several(row_line) || several(col_line);
    end

    // A single live match line can never look ambiguous.
    always_comb begin
        if ($countones(match) == 1) begin
            AST_SINGLE_NOT_MULTI: assert (!multi && any); // R5
        end
    end
endmodule

// File: rtl/tlb_pay_ram.sv
// Payload RAM: one translation record per entry, written by index, with
// two asynchronous read ports (lookup path and inspection path).
module tlb_pay_ram
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_pay_t         wr_pay,
    input  logic [IDX_W-1:0] a_idx,
    output tlb_pay_t         a_pay,
    input  logic [IDX_W-1:0] b_idx,
    output tlb_pay_t         b_pay
);
    tlb_pay_t mem [ENTRIES];

    // Clear on reset, otherwise store the payload on an indexed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_pay;
        end
    end

    assign a_pay = mem[a_idx];
    assign b_pay = mem[b_idx];
endmodule

// File: rtl/tlb_grid_top.sv
// Grid-encoded fully associative translation buffer. Key compare, grid
// index rebuild and payload read happen in one cycle; lookup and read-port
// results are registered. Assumes GRID_DIM is a power of two.
module tlb_grid_top
    import tlb_pkg::*;
#(
    parameter  int GRID_DIM = 8,
    localparam int CRD_W    = $clog2(GRID_DIM),
    localparam int IDX_W    = 2 * CRD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_nocache,
    input  logic              wr_dirty,
    input  logic              wr_pvalid,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              lk_hit,
    output logic              lk_multi,
    output logic [IDX_W-1:0]  lk_index,
    output logic [VA_W-1:0]   lk_pa,
    output logic              lk_nocache,
    output logic              lk_dirty,
    output logic              lk_pvalid,
    output logic [VPN_W-1:0]  rd_vpn,
    output logic [ASID_W-1:0] rd_asid,
    output logic              rd_glob,
    output logic [PFN_W-1:0]  rd_pfn,
    output logic              rd_nocache,
    output logic              rd_dirty,
    output logic              rd_pvalid
);
    localparam int ENTRIES = GRID_DIM * GRID_DIM;

    tlb_key_t           wkey, rkey;
    tlb_pay_t           wpay, hit_pay, rpay;
    logic [ENTRIES-1:0] cam_match;
    logic [CRD_W-1:0]   row_crd, col_crd;
    logic               any_match, multi_match;
    logic [IDX_W-1:0]   hit_idx;

    assign wkey = '{vpn: wr_vpn, asid: wr_asid, glob: wr_glob};
    assign wpay = '{pfn: wr_pfn, nocache: wr_nocache, dirty: wr_dirty, pvalid: wr_pvalid};

    tlb_key_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wkey),
        .rd_idx(rd_idx), .rd_key(rkey),
        .lk_vpn(lk_va[VA_W-1:OFF_W]), .lk_asid(lk_asid), .match(cam_match)
    );

    tlb_grid_enc #(.DIM(GRID_DIM)) u_enc (
        .match(cam_match), .row_crd(row_crd), .col_crd(col_crd),
        .any(any_match), .multi(multi_match)
    );

    // Entry index is the row coordinate above the column coordinate.
    assign hit_idx = {row_crd, col_crd};

    tlb_pay_ram #(.ENTRIES(ENTRIES)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_pay(wpay),
        .a_idx(hit_idx), .a_pay(hit_pay), .b_idx(rd_idx), .b_pay(rpay)
    );

    // Register the lookup result; misses and ambiguous matches read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !any_match || multi_match) begin
            lk_hit     <= 1'b0;
            lk_multi   <= rst_n && multi_match;
            lk_index   <= '0;
            lk_pa      <= '0;
            lk_nocache <= 1'b0;
            lk_dirty   <= 1'b0;
            lk_pvalid  <= 1'b0;
        end else begin
            lk_hit     <= 1'b1;
            lk_multi   <= 1'b0;
            lk_index   <= hit_idx;
            lk_pa      <= {hit_pay.pfn, lk_va[OFF_W-1:0]};
            lk_nocache <= hit_pay.nocache;
            lk_dirty   <= hit_pay.dirty;
            lk_pvalid  <= hit_pay.pvalid;
        end
    end

    // Register the inspection port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {rd_vpn, rd_asid, rd_glob}            <= '0;
            {rd_pfn, rd_nocache, rd_dirty, rd_pvalid} <= '0;
        end else begin
            {rd_vpn, rd_asid, rd_glob}            <= rkey;
            {rd_pfn, rd_nocache, rd_dirty, rd_pvalid} <= rpay;
        end
    end

    AST_HIT_NOT_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> !lk_multi); // R8
    AST_ONE_MATCH_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cam_match) == 1) |=> lk_hit); // R2
    AST_MANY_MATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cam_match) > 1) |=> (lk_multi && lk_pa == '0)); // R8
    AST_NO_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cam_match == '0) |=> (!lk_hit && !lk_multi && lk_pa == '0 && lk_index == '0)); // R7
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[OFF_W-1:0] == $past(lk_va[OFF_W-1:0]))); // R6
endmodule

// File: tb/sim_tlb_grid_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected results computed from a
// reference array model; a monitor pops and compares them when due.
module sim_tlb_grid_top;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_va = '0;
    logic [5:0]  lk_asid = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0;
    logic [5:0]  wr_asid = '0;
    logic        wr_glob = 1'b0;
    logic [19:0] wr_pfn = '0;
    logic        wr_nocache = 1'b0, wr_dirty = 1'b0, wr_pvalid = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic        lk_hit, lk_multi, lk_nocache, lk_dirty, lk_pvalid;
    logic [5:0]  lk_index;
    logic [31:0] lk_pa;
    logic [19:0] rd_vpn, rd_pfn;
    logic [5:0]  rd_asid;
    logic        rd_glob, rd_nocache, rd_dirty, rd_pvalid;

    tlb_grid_top u0 (.*);

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;

    // Reference model.
    bit        m_used [N];
    bit [19:0] m_vpn  [N];
    bit [5:0]  m_asid [N];
    bit        m_glob [N];
    bit [19:0] m_pfn  [N];
    bit        m_nc [N], m_d [N], m_v [N];

    typedef struct {
        bit        is_rd;
        int        req;
        int        due;
        bit        hit, multi;
        bit [5:0]  idx;
        bit [31:0] pa;
        bit        nc, d, v;
        bit [19:0] vpn;
        bit [5:0]  asid;
        bit        glob;
    } item_t;
    item_t sb [$];

    function automatic item_t expect_lookup(bit [31:0] va, bit [5:0] asid, int req);
        item_t it;
        int hits = 0;
        int who = 0;
        it = '{default: 0};
        it.req = req;
        for (int e = 0; e < N; e++)
            if (m_used[e] && m_vpn[e] == va[31:12] && (m_glob[e] || m_asid[e] == asid)) begin
                hits++;
                who = e;
            end
        if (hits == 1) begin
            it.hit = 1; it.idx = 6'(who);
            it.pa = {m_pfn[who], va[11:0]};
            it.nc = m_nc[who]; it.d = m_d[who]; it.v = m_v[who];
        end else if (hits > 1) begin
            it.multi = 1;
        end
        return it;
    endfunction

    task automatic do_lookup(input bit [31:0] va, input bit [5:0] asid, input int req);
        item_t it;
        @(negedge clk);
        wr_en = 1'b0; lk_va = va; lk_asid = asid;
        it = expect_lookup(va, asid, req);
        it.due = cyc + 1;
        sb.push_back(it);
    endtask

    task automatic set_write(input int idx, input bit [19:0] vpn, input bit [5:0] asid,
                             input bit g, input bit [19:0] pfn, input bit nc, input bit d,
                             input bit v);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_vpn = vpn; wr_asid = asid; wr_glob = g;
        wr_pfn = pfn; wr_nocache = nc; wr_dirty = d; wr_pvalid = v;
        m_used[idx] = 1; m_vpn[idx] = vpn; m_asid[idx] = asid; m_glob[idx] = g;
        m_pfn[idx] = pfn; m_nc[idx] = nc; m_d[idx] = d; m_v[idx] = v;
    endtask

    task automatic do_write(input int idx, input bit [19:0] vpn, input bit [5:0] asid,
                            input bit g, input bit [19:0] pfn, input bit nc, input bit d,
                            input bit v);
        @(negedge clk);
        set_write(idx, vpn, asid, g, pfn, nc, d, v);
    endtask

    // R9: lookup in the write's own cycle is judged against the old model.
    task automatic do_write_lookup(input int idx, input bit [19:0] vpn, input bit [5:0] asid,
                                   input bit [19:0] pfn);
        item_t it;
        @(negedge clk);
        lk_va = {vpn, 12'h5A5}; lk_asid = asid;
        it = expect_lookup({vpn, 12'h5A5}, asid, 9);
        it.due = cyc + 1;
        sb.push_back(it);
        set_write(idx, vpn, asid, 1'b0, pfn, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic do_read(input int idx, input int req);
        item_t it;
        @(negedge clk);
        wr_en = 1'b0; rd_idx = 6'(idx);
        it = '{default: 0};
        it.is_rd = 1; it.req = req; it.due = cyc + 1;
        it.vpn = m_vpn[idx]; it.asid = m_asid[idx]; it.glob = m_glob[idx];
        it.pa = {12'h0, m_pfn[idx]}; it.nc = m_nc[idx]; it.d = m_d[idx]; it.v = m_v[idx];
        sb.push_back(it);
    endtask

    // Monitor: compare every due item against the registered outputs.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.is_rd) begin
                if ({rd_vpn, rd_asid, rd_glob, rd_pfn, rd_nocache, rd_dirty, rd_pvalid} !==
                    {it.vpn, it.asid, it.glob, it.pa[19:0], it.nc, it.d, it.v}) begin
                    fails++;
                    $display("FAIL R%0d read: got vpn=%h asid=%h g=%b pfn=%h f=%b%b%b exp vpn=%h asid=%h g=%b pfn=%h f=%b%b%b",
                             it.req, rd_vpn, rd_asid, rd_glob, rd_pfn, rd_nocache, rd_dirty, rd_pvalid,
                             it.vpn, it.asid, it.glob, it.pa[19:0], it.nc, it.d, it.v);
                end
            end else begin
                if ({lk_hit, lk_multi, lk_index, lk_pa, lk_nocache, lk_dirty, lk_pvalid} !==
                    {it.hit, it.multi, it.idx, it.pa, it.nc, it.d, it.v}) begin
                    fails++;
                    $display("FAIL R%0d lookup: got hit=%b multi=%b idx=%0d pa=%h f=%b%b%b exp hit=%b multi=%b idx=%0d pa=%h f=%b%b%b",
                             it.req, lk_hit, lk_multi, lk_index, lk_pa, lk_nocache, lk_dirty, lk_pvalid,
                             it.hit, it.multi, it.idx, it.pa, it.nc, it.d, it.v);
                end
            end
        end
    end

    function automatic bit [19:0] vpn_of(int i);  return 20'h40000 + 20'(i) * 20'h123; endfunction
    function automatic bit [5:0]  asid_of(int i); return 6'(i) ^ 6'h15; endfunction
    function automatic bit        glob_of(int i); return (i % 9) == 0; endfunction
    function automatic bit [19:0] pfn_of(int i);  return 20'hA0000 ^ (20'(i) * 20'h31); endfunction

    task automatic write_std(input int i);
        do_write(i, vpn_of(i), asid_of(i), glob_of(i), pfn_of(i), i[0], i[1], ~i[2]);
    endtask

    task automatic finish_run;
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R2 scoreboard: got %0d pending items exp 0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL R1 watchdog: got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state visible on every output.
        @(negedge clk);
        checks++;
        if ({lk_hit, lk_multi, lk_index, lk_pa, lk_nocache, lk_dirty, lk_pvalid,
             rd_vpn, rd_asid, rd_glob, rd_pfn, rd_nocache, rd_dirty, rd_pvalid} !== '0) begin
            fails++;
            $display("FAIL R1 reset outputs: got hit=%b multi=%b pa=%h rdvpn=%h exp all 0",
                     lk_hit, lk_multi, lk_pa, rd_vpn);
        end
        // R1: unwritten entries match nothing, even an all-zero key.
        do_lookup(32'h0, 6'h0, 1);
        do_read(17, 1);

        // Fill every position of the grid.
        for (int i = 0; i < N; i++) write_std(i);

        // R2 R5 R6: each entry found at its own index with its own payload.
        for (int i = 0; i < N; i++)
            do_lookup({vpn_of(i), 12'(i * 37)}, asid_of(i), 5);
        // R10: inspection of every entry.
        for (int i = 0; i < N; i++) do_read(i, 10);

        // R3: global entries hit with a foreign identifier.
        for (int i = 0; i < N; i += 9)
            do_lookup({vpn_of(i), 12'hFFF}, asid_of(i) ^ 6'h3F, 3);
        // R4: non-global entries miss with an off-by-one identifier.
        for (int i = 1; i < N; i += 7)
            if (!glob_of(i)) do_lookup({vpn_of(i), 12'h001}, asid_of(i) ^ 6'h01, 4);
        // R7: unmapped pages miss.
        do_lookup(32'h0000_1234, 6'h00, 7);
        do_lookup(32'hFFFF_F000, 6'h2A, 7);

        // R8: duplicate in a different row and column (entries 9 and 63).
        do_write(63, vpn_of(9), asid_of(9), 1'b0, 20'h12345, 1'b0, 1'b0, 1'b1);
        do_lookup({vpn_of(9), 12'h080}, asid_of(9), 8);
        // R8: duplicate inside one row (entries 10 and 11), only columns differ.
        do_write(10, vpn_of(11), asid_of(11), 1'b1, 20'h0BEEF, 1'b1, 1'b0, 1'b0);
        do_lookup({vpn_of(11), 12'h010}, asid_of(11), 8);
        // R8: a foreign identifier still hits only the global copy of 10.
        do_lookup({vpn_of(11), 12'h010}, asid_of(11) ^ 6'h02, 8);
        // Restore, then the previously ambiguous keys resolve again.
        write_std(63);
        write_std(10);
        do_lookup({vpn_of(9), 12'h080}, asid_of(9), 8);
        do_lookup({vpn_of(11), 12'h010}, asid_of(11), 8);
        do_read(10, 10);

        // R9: write with a same-cycle lookup, then a next-cycle lookup.
        do_write_lookup(20, 20'h0ABCD, 6'h05, 20'h77777);
        do_lookup({20'h0ABCD, 12'h321}, 6'h05, 9);
        do_lookup({vpn_of(20), 12'h321}, asid_of(20), 9);
        do_read(20, 10);

        finish_run();
    end
endmodule